// File: doc/BRIEF.md
# Cache Victim Way Selector

This block chooses the way of a four-way set-associative cache that a linefill will overwrite. When a linefill request arrives, it picks the victim under one of two replacement policies. A single run-time control bit selects the policy: a round-robin pointer or a free-running pseudo-random sequence. A per-way lockdown mask takes ways out of allocation. Software can use the mask to pin lines that must stay resident. It can also use the mask to confine new fills to a few ways, so that streaming data does not pollute the rest of the cache.

The request is a single-cycle strobe with no back-pressure. The selector accepts a request in every cycle, so there is no ready signal and a request is never stalled. The answer is a registered result with a valid flag that pulses for one cycle. The downstream tag and data logic must take the victim in the cycle the flag is high, because the flag does not wait. While the cache is disabled, or while every way is locked, a request is answered with the flag low and the replacement state stays unchanged.

Top module: `cache_victim_select`

## Requirements
- R1: `victim_valid` is high in the cycle after a clock edge where `fill_req` and `cache_en` are high and at least one way is unlocked. In every other cycle it is low.
- R2: `policy_sel` is sampled with the request. The value 0 selects round-robin and the value 1 selects pseudo-random.
- R3: Bit i of `lock_mask` set to 1 locks way i. A locked way is never reported as a victim.
- R4: Round-robin picks the first unlocked way at or above the pointer, wrapping from way 3 to way 0. The pointer resets to 0. After each round-robin allocation it becomes (chosen way + 1) mod 4, and it changes at no other time.
- R5: While `cache_en` is low, a request makes no allocation and leaves the round-robin pointer unchanged.
- R6: When all four ways are locked, a request gives `victim_valid` low and leaves the round-robin pointer unchanged.
- R7: The pseudo-random source is a 4-bit register s. It resets to 0001 and, from the first edge after reset, steps on every edge to {s[2:0], s[3]^s[2]}. Its low two bits at the request edge give a candidate way. The victim is the first unlocked way at or above that candidate, wrapping from way 3 to way 0.
- R8: While `victim_valid` is high, `victim_onehot` has exactly the bit set whose index equals `victim_idx`. While it is low, `victim_onehot` is zero.
- R9: During and just after reset, `victim_valid` is 0, `victim_onehot` is 0 and `victim_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache enable; no allocation while low |
| policy_sel | input | 1 | 0 = round-robin, 1 = pseudo-random |
| lock_mask | input | 4 | Per-way lockdown, 1 = way excluded |
| fill_req | input | 1 | Linefill request strobe |
| victim_valid | output | 1 | Victim result valid (one-cycle pulse) |
| victim_onehot | output | 4 | Chosen way, one-hot |
| victim_idx | output | 2 | Chosen way, binary |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples the request. This covers the valid flag, the one-hot and binary victim, and the pointer advance that shows up in the following round-robin choice. The bench drives inputs on the falling edge. A reference model updates on the rising edge from the same inputs, and the bench compares the outputs with the model on the next falling edge, half a period after the outputs settle. The model's pseudo-random register steps on every rising edge after reset, as the DUT's does. This lets the random choices, the round-robin choices and the disabled and fully locked cases all be checked cycle-exactly over all sixteen lock masks under both policies.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic {
    POL_ROUND = 1'b0,
    POL_RANDOM = 1'b1
  } policy_e;
endpackage

// File: rtl/cvs_lfsr.sv
module cvs_lfsr #(
  parameter int W = 4,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = state[W-1] ^ state[W-2];

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[W-2:0], fb};
  end

  p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/cvs_find_unlocked.sv
module cvs_find_unlocked #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [IDX_W-1:0] start,
  input  logic [WAYS-1:0]  lock_mask,
  output logic [IDX_W-1:0] sel,
  output logic             found
);
  logic [IDX_W-1:0] w;

  always_comb begin
    sel   = start;
    found = 1'b0;
    w     = '0;
    for (int k = WAYS - 1; k >= 0; k--) begin
      w = start + IDX_W'(k);
      if (!lock_mask[w]) begin
        sel   = w;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cvs_rr_ptr.sv
module cvs_rr_ptr #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [IDX_W-1:0] chosen,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= chosen + IDX_W'(1);
  end

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr));
endmodule

// File: rtl/cache_victim_select.sv
module cache_victim_select #(
  parameter int WAYS = 4,
  parameter int LFSR_W = 4,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 1,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cache_en,
  input  logic             policy_sel,
  input  logic [WAYS-1:0]  lock_mask,
  input  logic             fill_req,
  output logic             victim_valid,
  output logic [WAYS-1:0]  victim_onehot,
  output logic [IDX_W-1:0] victim_idx
);
  import cvs_pkg::*;

  logic [LFSR_W-1:0] lfsr_q;
  logic [IDX_W-1:0]  rr_q;
  logic [IDX_W-1:0]  start;
  logic [IDX_W-1:0]  pick;
  logic              any_free;
  logic              alloc;
  policy_e           pol;

  assign pol   = policy_e'(policy_sel);
  assign start = (pol == POL_RANDOM) ? lfsr_q[IDX_W-1:0] : rr_q;
  assign alloc = fill_req & cache_en & any_free;

  cvs_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(lfsr_q));

  cvs_find_unlocked #(.WAYS(WAYS)) u_find (
    .start(start), .lock_mask(lock_mask), .sel(pick), .found(any_free));

  cvs_rr_ptr #(.WAYS(WAYS)) u_rr (
    .clk(clk), .rst_n(rst_n), .advance(alloc && pol == POL_ROUND),
    .chosen(pick), .ptr(rr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_valid  <= 1'b0;
      victim_onehot <= '0;
      victim_idx    <= '0;
    end else begin
      victim_valid  <= alloc;
      victim_onehot <= alloc ? (WAYS'(1) << pick) : '0;
      if (alloc) victim_idx <= pick;
    end
  end

  p_no_locked_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (victim_onehot & $past(lock_mask)) == '0);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && cache_en && lock_mask != '1) |=> victim_valid);
  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cache_en) |=> !victim_valid);
  p_all_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mask == '1) |=> !victim_valid);
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> ($countones(victim_onehot) == 1 && victim_onehot[victim_idx]));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_valid |-> victim_onehot == '0);
endmodule

// File: tb/cache_victim_select_bench.sv
module cache_victim_select_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cache_en = 1'b0;
  logic       policy_sel = 1'b0;
  logic [3:0] lock_mask = 4'h0;
  logic       fill_req = 1'b0;
  logic       victim_valid;
  logic [3:0] victim_onehot;
  logic [1:0] victim_idx;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_victim_select u_cache_victim_select (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .policy_sel(policy_sel),
    .lock_mask(lock_mask), .fill_req(fill_req), .victim_valid(victim_valid),
    .victim_onehot(victim_onehot), .victim_idx(victim_idx));

  // reference model built from the requirements
  logic [3:0] m_lfsr;
  logic [1:0] m_ptr;
  logic       e_valid;
  logic [1:0] e_idx;

  function automatic logic [2:0] first_free(input logic [1:0] s, input logic [3:0] m);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] w;
      w = 2'((s + k) % 4);
      if (!m[w]) return {1'b1, w};
    end
    return 3'b000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lfsr <= 4'b0001; m_ptr <= 2'd0; e_valid <= 1'b0; e_idx <= 2'd0;
    end else begin
      logic [2:0] r;
      m_lfsr <= {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
      r = first_free(policy_sel ? m_lfsr[1:0] : m_ptr, lock_mask);
      e_valid <= fill_req && cache_en && r[2];
      if (fill_req && cache_en && r[2]) begin
        e_idx <= r[1:0];
        if (!policy_sel) m_ptr <= 2'(r[1:0] + 1);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // checks half a period after each rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(policy_sel ? "R1/R7 valid" : "R1/R4 valid", 32'(victim_valid), 32'(e_valid));
      if (e_valid) begin
        check("R3 locked victim", 32'(victim_onehot & lock_mask_q), 0);
        check(policy_sel_q ? "R7 idx" : "R4 idx", 32'(victim_idx), 32'(e_idx));
        check("R8 onehot", 32'(victim_onehot), 32'(4'b1 << e_idx));
      end else begin
        check("R8 onehot idle", 32'(victim_onehot), 0);
      end
    end
  end

  logic [3:0] lock_mask_q;
  logic       policy_sel_q;
  always @(posedge clk) begin lock_mask_q <= lock_mask; policy_sel_q <= policy_sel; end

  task automatic step(input logic req);
    fill_req = req;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 valid", 32'(victim_valid), 0);
    check("R9 onehot", 32'(victim_onehot), 0);
    check("R9 idx", 32'(victim_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", 32'(victim_valid), 0);
    cache_en = 1'b1;
    // R2 R3 R4 R6 R7: both policies over every lock mask
    for (int p = 0; p < 2; p++) begin
      policy_sel = 1'(p);
      for (int m = 0; m < 16; m++) begin
        lock_mask = 4'(m);
        for (int n = 0; n < 7; n++) begin
          step(1'b1);
          if (n % 3 == 2) step(1'b0);
        end
        step(1'b0);
      end
    end
    // R5: disabled cache ignores requests and keeps the pointer
    policy_sel = 1'b0; lock_mask = 4'h0;
    step(1'b1); step(1'b0);
    cache_en = 1'b0;
    for (int n = 0; n < 6; n++) step(1'b1);
    cache_en = 1'b1;
    step(1'b1); step(1'b1); step(1'b0);
    // R2: policy switching between back-to-back requests
    for (int n = 0; n < 40; n++) begin
      policy_sel = 1'(n % 3 == 0);
      lock_mask = 4'((n * 5) % 16);
      step(1'b1);
    end
    step(1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule